// File: doc/BRIEF.md
# Capture/Compare Timer with Pulse Measurement

This block is a parameterised up-counter (16 bits by default) with two registers. Each register can either capture the count or compare against it. The counter advances on a prescaled tick strobe from elsewhere in the chip, or on valid edges of the first measurement input. Four run modes are available: halted, free-running, cleared by an edge on the first input, and cleared after a match with register 0. The two inputs arrive already filtered and synchronous to `clk`.

Capture routing is cross-coupled. Register 1 always captures on the first input (`in0_i`). Register 0 captures on either input, chosen by a control bit. This lets one free-running count measure two pulse widths at the same time. In compare mode, a register raises a one-cycle interrupt when the count equals it. The same match can also toggle an output flip-flop. Using register 0 as the period and register 1 as the duty point turns the block into a pulse generator.

Software reaches the block through a small word-wide bus. Reads return data one cycle later and are marked by `rvalid_o`. The bus addresses are: 0 count (read only), 1 register 0, 2 register 1, 3 run control, 4 edge select, 5 output control, 6 status.

Top module: `cct_timer`

## Requirements
- R1: After a synchronous reset, the following all read as 0: the count, both registers, run control, edge select and status. `tout_o`, `ovf_o`, `irq_cc0_o` and `irq_cc1_o` are all 0.
- R2: Run control bits [1:0] select the run mode: 00 halted, 01 free-running, 10 clear on an `in0_i` edge, 11 clear on a register-0 match. In halted mode the count is forced to zero and stays there. The register contents are kept.
- R3: Run control bit 5 selects the step source. At 0 the count advances once per cycle with `tick_i` high. At 1 it advances once per valid `in0_i` edge, and `tick_i` is ignored.
- R4: Edge select bits [1:0] apply to `in0_i` and bits [3:2] to `in1_i`. The codes are: 00 falling, 01 rising, 10 no edge is ever valid, 11 both edges.
- R5: Run control bit 2 puts register 0 in capture mode and bit 3 does the same for register 1. Register 1 captures on `in0_i`. Register 0 captures on `in1_i` when bit 4 is 0, and on `in0_i` when bit 4 is 1. The stored value is the count before that cycle's step.
- R6: A read never causes a capture. A read that coincides with a capture returns the old value, and the capture still takes effect.
- R7: A register in compare mode matches when the count equals it in a cycle where the count steps. The match, or a capture, pulses that register's interrupt one cycle later.
- R8: In mode 11, a match with register 0 returns the count to zero instead of incrementing it, so the period is register 0 plus one steps.
- R9: In mode 10, a valid `in0_i` edge sets the count to zero.
- R10: Status bit 0 sets when the count steps from all ones. This covers the wrap in free-running mode and a register-0 value of all ones in mode 11. Writing 1 to status bit 0 clears the flag. The flag is also driven on `ovf_o`.
- R11: In output control, bit 0 enables `tout_o`, bit 1 makes register-0 matches toggle the flip-flop, and bit 2 does the same for register-1 matches. A write with bit 3 set loads bit 4 into the flip-flop. When no match toggles it and no load occurs, the flip-flop holds.
- R12: In pulse-generator use (mode 11, both toggles enabled, flip-flop loaded to 0), the output rises after the register-1 match. It falls after the register-0 match, when the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled count strobe |
| in0_i | input | 1 | First filtered measurement input |
| in1_i | input | 1 | Second filtered measurement input |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 3 | Bus word address |
| wdata_i | input | CNT_W | Bus write data |
| rdata_o | output | CNT_W | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| tout_o | output | 1 | Timer output |
| irq_cc0_o | output | 1 | Register 0 match/capture pulse |
| irq_cc1_o | output | 1 | Register 1 match/capture pulse |
| ovf_o | output | 1 | Overflow flag |

## Verification
The assertions assume the inputs are synchronous to `clk` and already free of glitches. They also assume a register only changes through a capture or a bus write to its own address, and that `tick_i` is a level sampled each cycle. The stimulus changes every input at the falling clock edge and issues one bus operation at a time. It only raises a measurement input while the count is frozen between tick bursts, so every captured value is known exactly. Edge-clear mode and edge-driven stepping are never enabled together.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned NUM_CC = 2;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CC0  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CC1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_EDGE = 3'd4;
  localparam logic [ADDR_W-1:0] A_OUT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;

  typedef enum logic [1:0] {
    RUN_HALT     = 2'b00,
    RUN_FREE     = 2'b01,
    RUN_EXTCLR   = 2'b10,
    RUN_MATCHCLR = 2'b11
  } run_mode_e;

  typedef enum logic [1:0] {
    EDG_FALL = 2'b00,
    EDG_RISE = 2'b01,
    EDG_OFF  = 2'b10,
    EDG_BOTH = 2'b11
  } edge_sel_e;

  // packed MSB first: clk_sel=bit5 ... mode=bits[1:0]
  typedef struct packed {
    logic      clk_sel;
    logic      cc0_src;
    logic      cc1_cap;
    logic      cc0_cap;
    run_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/cct_edge.sv
module cct_edge (
  input  logic       clk,
  input  logic       sig_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  import cct_pkg::*;

  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) prev_q <= sig_i;

  assign rise = sig_i & ~prev_q;
  assign fall = ~sig_i & prev_q;

  always_comb begin
    unique case (edge_sel_e'(sel_i))
      EDG_FALL: edge_o = fall;
      EDG_RISE: edge_o = rise;
      EDG_BOTH: edge_o = rise | fall;
      default:  edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cct_count.sv
module cct_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cct_pkg::run_mode_e mode_i,
  input  logic             step_i,
  input  logic             ext_clr_i,
  input  logic             match0_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  import cct_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic ext_zero;
  logic wrap;

  assign ext_zero = (mode_i == RUN_EXTCLR) && ext_clr_i;
  assign wrap     = step_i && (cnt_o == CNT_MAX) && (mode_i != RUN_HALT) && !ext_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (mode_i == RUN_HALT) begin
      cnt_o <= '0;
    end else if (ext_zero) begin
      cnt_o <= '0;
    end else if (step_i) begin
      if (mode_i == RUN_MATCHCLR && match0_i) cnt_o <= '0;
      else                                     cnt_o <= cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ovf_o <= 1'b0;
    else if (wrap)      ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  // R2: halted mode forces the count to zero
  a_r2_halt_zero: assert property (@(posedge clk) disable iff (rst)
    (mode_i == RUN_HALT) |=> (cnt_o == '0));

  // R8: match with register 0 in clear-on-match mode restarts the count
  a_r8_match_restart: assert property (@(posedge clk) disable iff (rst)
    (mode_i == RUN_MATCHCLR && step_i && match0_i) |=> (cnt_o == '0));

  // R9: valid edge in edge-clear mode restarts the count
  a_r9_ext_restart: assert property (@(posedge clk) disable iff (rst)
    ext_zero |=> (cnt_o == '0));

  // R10: the flag only rises after a step out of all ones
  a_r10_ovf_from_max: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> ($past(cnt_o) == CNT_MAX));
endmodule

// File: rtl/cct_ccreg.sv
module cct_ccreg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_mode_i,
  input  logic             cap_ev_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] val_o,
  output logic             match_o,
  output logic             irq_o
);
  logic capture;

  assign capture = cap_mode_i && cap_ev_i;
  assign match_o = !cap_mode_i && step_i && (cnt_i == val_o);

  always_ff @(posedge clk) begin
    if (rst)          val_o <= '0;
    else if (capture) val_o <= cnt_i;
    else if (wr_i)    val_o <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= capture | match_o;
  end

  // R6: without a capture or a write the register holds (reads do nothing)
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!capture && !wr_i) |=> $stable(val_o));

  // R5: a capture stores the count seen in that cycle
  a_r5_capture_value: assert property (@(posedge clk) disable iff (rst)
    capture |=> (val_o == $past(cnt_i)));

  // R7: a match pulses the interrupt in the next cycle
  a_r7_match_irq: assert property (@(posedge clk) disable iff (rst)
    match_o |=> irq_o);
endmodule

// File: rtl/cct_timer.sv
module cct_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             in0_i,
  input  logic             in1_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             rvalid_o,
  output logic             tout_o,
  output logic             irq_cc0_o,
  output logic             irq_cc1_o,
  output logic             ovf_o
);
  import cct_pkg::*;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t      ctrl_q;
  logic [3:0] edge_q;
  logic [2:0] outc_q;
  logic       ff_q;

  logic e0, e1, step;
  logic [CNT_W-1:0] cnt;
  logic [NUM_CC-1:0] cap_mode, cap_ev, cc_wr, match, irq;
  logic [CNT_W-1:0] cc_val [NUM_CC];
  logic load;

  // ---------------- control registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      edge_q <= '0;
      outc_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL: ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        A_EDGE: edge_q <= wdata_i[3:0];
        A_OUT:  outc_q <= wdata_i[2:0];
        default: ;
      endcase
    end
  end

  // ---------------- edge detection ----------------
  cct_edge u_edge0 (.clk(clk), .sig_i(in0_i), .sel_i(edge_q[1:0]), .edge_o(e0));
  cct_edge u_edge1 (.clk(clk), .sig_i(in1_i), .sel_i(edge_q[3:2]), .edge_o(e1));

  assign step = (ctrl_q.mode != RUN_HALT) && (ctrl_q.clk_sel ? e0 : tick_i);

  // ---------------- counter ----------------
  cct_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .mode_i(ctrl_q.mode), .step_i(step),
    .ext_clr_i(e0), .match0_i(match[0]),
    .ovf_clr_i(wr_en_i && addr_i == A_STAT && wdata_i[0]),
    .cnt_o(cnt), .ovf_o(ovf_o)
  );

  // ---------------- capture/compare registers ----------------
  assign cap_mode = {ctrl_q.cc1_cap, ctrl_q.cc0_cap};
  assign cap_ev   = {e0, (ctrl_q.cc0_src ? e0 : e1)};

  for (genvar i = 0; i < NUM_CC; i++) begin : g_cc
    assign cc_wr[i] = wr_en_i && (addr_i == A_CC0 + 3'(i));
    cct_ccreg #(.CNT_W(CNT_W)) u_cc (
      .clk(clk), .rst(rst), .cap_mode_i(cap_mode[i]), .cap_ev_i(cap_ev[i]),
      .wr_i(cc_wr[i]), .wdata_i(wdata_i), .cnt_i(cnt), .step_i(step),
      .val_o(cc_val[i]), .match_o(match[i]), .irq_o(irq[i])
    );
  end

  assign irq_cc0_o = irq[0];
  assign irq_cc1_o = irq[1];

  // ---------------- output flip-flop ----------------
  assign load = wr_en_i && (addr_i == A_OUT) && wdata_i[3];

  always_ff @(posedge clk) begin
    if (rst)       ff_q <= 1'b0;
    else if (load) ff_q <= wdata_i[4];
    else           ff_q <= ff_q ^ (match[0] & outc_q[1]) ^ (match[1] & outc_q[2]);
  end

  assign tout_o = ff_q & outc_q[0];

  // ---------------- read port ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) begin
        case (addr_i)
          A_CNT:   rdata_o <= cnt;
          A_CC0:   rdata_o <= cc_val[0];
          A_CC1:   rdata_o <= cc_val[1];
          A_CTRL:  rdata_o <= CNT_W'(ctrl_q);
          A_EDGE:  rdata_o <= CNT_W'(edge_q);
          A_OUT:   rdata_o <= CNT_W'(outc_q);
          A_STAT:  rdata_o <= CNT_W'(ovf_o);
          default: rdata_o <= '0;
        endcase
      end
    end
  end

  // R4: with in0 edges switched off, register 1 is only changed by writes
  a_r4_off_no_capture: assert property (@(posedge clk) disable iff (rst)
    (edge_q[1:0] == 2'b10 && !cc_wr[1]) |=> $stable(cc_val[1]));

  // R11: without an enabled match or a load the flip-flop holds
  a_r11_ff_quiet: assert property (@(posedge clk) disable iff (rst)
    (!load && !(match[0] && outc_q[1]) && !(match[1] && outc_q[2])) |=> $stable(ff_q));

  // R3: with edge stepping selected the count ignores tick_i
  a_r3_edge_step: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.clk_sel && ctrl_q.mode == RUN_FREE && !e0) |=> $stable(cnt));
endmodule

// File: tb/tb_cct_timer.sv
module tb_cct_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 199000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, in0_i = 1'b0, in1_i = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rvalid_o, tout_o, irq_cc0_o, irq_cc1_o, ovf_o;

  cct_timer #(.CNT_W(16)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  int n_cmp = 0, n_bad = 0;
  int irq0_n = 0, irq1_n = 0;
  bit finished = 0;

  // monitor: pops expected read data and counts interrupt pulses
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_cc0_o) irq0_n++;
      if (irq_cc1_o) irq1_n++;
      if (rvalid_o) begin
        item_t it;
        n_cmp++;
        if (sb_q.size() == 0) begin
          n_bad++;
          $display("FAIL scoreboard: unexpected read data actual=%h expected=none", rdata_o);
        end else begin
          it = sb_q.pop_front();
          if (rdata_o !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, rdata_o, it.exp);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    sb_q.push_back('{exp: exp, tag: tag});
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic set_in0(input logic v);
    @(negedge clk); in0_i = v;
  endtask

  task automatic set_in1(input logic v);
    @(negedge clk); in1_i = v;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 tout", {15'd0, tout_o}, 16'd0);
    chk("R1 ovf", {15'd0, ovf_o}, 16'd0);
    chk("R1 irq", {14'd0, irq_cc1_o, irq_cc0_o}, 16'd0);
    rd(3'd0, 16'd0, "R1 count");
    rd(3'd1, 16'd0, "R1 reg0");
    rd(3'd2, 16'd0, "R1 reg1");
    rd(3'd3, 16'd0, "R1 ctrl");
    rd(3'd4, 16'd0, "R1 edge");
    rd(3'd6, 16'd0, "R1 status");

    // R2 halted: ticks do not move the count
    ticks(4);
    rd(3'd0, 16'd0, "R2 halted count");

    // R3 free-running on ticks
    wr(3'd3, 16'h0001);
    ticks(5);
    rd(3'd0, 16'd5, "R3 tick count");

    // R5 cross-coupled capture: reg1 <- in0 rise, reg0 <- in1 fall
    wr(3'd4, 16'h0001);
    wr(3'd3, 16'h000D);
    ticks(3);
    irq1_n = 0;
    set_in0(1'b1);
    ticks(4);
    set_in1(1'b1);
    ticks(2);
    set_in1(1'b0);
    rd(3'd1, 16'd14, "R5 reg0 from in1 fall");
    rd(3'd2, 16'd8, "R5 reg1 from in0 rise");
    chk("R7 capture irq", 16'(irq1_n), 16'd1);
    set_in0(1'b0);
    rd(3'd2, 16'd8, "R4 falling ignored with rise code");

    // R4 both edges
    wr(3'd4, 16'h0003);
    ticks(1);
    set_in0(1'b1);
    rd(3'd2, 16'd15, "R4 both: rise");
    ticks(1);
    set_in0(1'b0);
    rd(3'd2, 16'd16, "R4 both: fall");

    // R4 code 10 never valid
    wr(3'd4, 16'h0002);
    ticks(1);
    set_in0(1'b1);
    rd(3'd2, 16'd16, "R4 off code");
    set_in0(1'b0);

    // R6 read colliding with capture
    wr(3'd4, 16'h0001);
    ticks(1);
    @(negedge clk);
    sb_q.push_back('{exp: 16'd16, tag: "R6 collision old value"});
    rd_en_i = 1'b1; addr_i = 3'd2; in0_i = 1'b1;
    @(negedge clk); rd_en_i = 1'b0;
    rd(3'd2, 16'd18, "R6 capture landed");
    rd(3'd0, 16'd18, "R6 count read");
    rd(3'd1, 16'd14, "R6 reg0 untouched by reads");
    rd(3'd2, 16'd18, "R6 reg1 untouched by reads");
    set_in0(1'b0);

    // R9 clear on in0 edge
    wr(3'd3, 16'h0002);
    ticks(2);
    set_in0(1'b1);
    ticks(3);
    rd(3'd0, 16'd3, "R9 edge clear");
    set_in0(1'b0);

    // R3 event counting on in0 rises, tick ignored
    wr(3'd3, 16'h0021);
    ticks(4);
    set_in0(1'b1); set_in0(1'b0);
    set_in0(1'b1); set_in0(1'b0);
    set_in0(1'b1); set_in0(1'b0);
    rd(3'd0, 16'd6, "R3 event count");

    // R2 halt keeps registers; R8/R7 clear on match
    wr(3'd3, 16'h0000);
    rd(3'd0, 16'd0, "R2 halt clears count");
    rd(3'd1, 16'd14, "R2 halt keeps reg0");
    wr(3'd1, 16'd3);
    wr(3'd3, 16'h0003);
    irq0_n = 0;
    ticks(4);
    rd(3'd0, 16'd0, "R8 wrap after match");
    chk("R7 match irq one", 16'(irq0_n), 16'd1);
    ticks(6);
    rd(3'd0, 16'd2, "R8 period reg0+1");
    chk("R7 match irq two", 16'(irq0_n), 16'd2);

    // R12 pulse generator, R11 output control
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'd5);
    wr(3'd2, 16'd2);
    wr(3'd5, 16'h000F);
    wr(3'd3, 16'h0003);
    chk("R12 start low", {15'd0, tout_o}, 16'd0);
    ticks(3);
    chk("R12 high after reg1 match", {15'd0, tout_o}, 16'd1);
    ticks(3);
    chk("R12 low after reg0 match", {15'd0, tout_o}, 16'd0);
    rd(3'd0, 16'd0, "R12 count restarted");
    wr(3'd5, 16'h0006);
    ticks(3);
    chk("R11 output disabled", {15'd0, tout_o}, 16'd0);
    wr(3'd5, 16'h0019);
    chk("R11 load high", {15'd0, tout_o}, 16'd1);
    ticks(5);
    chk("R11 toggles off hold", {15'd0, tout_o}, 16'd1);

    // R10 overflow, free-running
    wr(3'd3, 16'h0000);
    wr(3'd5, 16'h0000);
    wr(3'd3, 16'h0001);
    ticks(65535);
    rd(3'd0, 16'hFFFF, "R10 count at max");
    rd(3'd6, 16'd0, "R10 no flag before wrap");
    ticks(1);
    rd(3'd6, 16'd1, "R10 flag after wrap");
    rd(3'd0, 16'd0, "R10 count wrapped");
    chk("R10 ovf port", {15'd0, ovf_o}, 16'd1);
    wr(3'd6, 16'h0001);
    rd(3'd6, 16'd0, "R10 flag cleared");

    // R10 overflow in clear-on-match with reg0 all ones
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'hFFFF);
    wr(3'd3, 16'h0003);
    ticks(65535);
    rd(3'd6, 16'd0, "R10 match mode before max step");
    ticks(1);
    rd(3'd6, 16'd1, "R10 match mode flag");
    rd(3'd0, 16'd0, "R10 match mode count");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
    end
    summary();
  end
endmodule